// File: doc/BRIEF.md
# Four-way data cache line-state controller

This block keeps the per-line state of a four-way set-associative data cache. Each line carries a tag, a data word and a two-bit state (invalid, valid or modified). The block answers CPU reads and writes and runs line fills and line writebacks through a single request/acknowledge memory port. A per-access input picks copyback or write-through handling. It comes from region matching outside the block, or from a default when no region matches.

In copyback handling a read or write miss fetches the whole line. A write hit marks the line modified. In write-through handling lines stay clean. Every write goes to memory, and a write miss does not allocate. A refill uses the lowest-numbered invalid way of the set first. When all ways are in use, a two-bit rotating pointer kept for each set picks the victim. A dirty victim is parked in a one-entry buffer and written out only after the new line has arrived.

Two commands act on the line state. One clears every line without any writeback. The other pushes one chosen line out to memory and then keeps it clean or drops it. While a fill, a write-through write or a writeback is outstanding, the block raises busy and ignores new requests and commands.

Top module: `cc_line_ctrl`

## Requirements
- R1: After synchronous reset every line is invalid, and `cpu_busy`, `mem_req` and `cpu_done` are low; the first access to any address therefore misses.
- R2: A read hit returns the cached word with `cpu_done` high in the cycle after the request is accepted, and makes no memory request.
- R3: A read miss, in either mode, issues one memory read (`mem_we`=0) of the requested line address and returns the memory word; the line is valid afterwards and later reads hit.
- R4: In copyback mode (`cpu_wt`=0) a write miss fetches the line and then holds the written word as a modified line; a write hit updates the word, marks the line modified and makes no memory request.
- R5: In write-through mode (`cpu_wt`=1) every write makes exactly one memory write (`mem_we`=1) of the written word at the access address; a hit also updates the cached word without marking it modified, and a miss allocates no line.
- R6: A refill places the line in the lowest-numbered invalid way of the set, if any, and leaves that set's rotating pointer unchanged.
- R7: When all four ways of the set hold valid or modified lines, the victim is the way named by the set's pointer, which then advances by one, wrapping modulo 4.
- R8: A modified victim's old word is written to its own line address only after the fill read of the new line has been acknowledged; a clean victim causes no write.
- R9: `cpu_busy` is high from the accepting edge of a fill, a write-through write or a push that writes back, until the last memory acknowledge. `mem_req` holds its address and direction until acknowledged. Requests offered while busy have no effect and produce no `cpu_done`.
- R10: The invalidate-all command (`cmd_inval_all`) makes every line invalid in one cycle without any memory write; modified data is discarded.
- R11: The push command (`cmd_push`) on a modified line at (`cmd_push_set`, `cmd_push_way`) writes its word to memory. The line then becomes invalid when `cmd_push_inval`=1 and stays valid and clean when it is 0. On a line that is not modified, a push makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, taken when not busy |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wt | input | 1 | Mode of this access: 1 = write-through, 0 = copyback |
| cpu_addr | input | ADDR_W | Line address; low SET_W bits select the set, the rest form the tag |
| cpu_wdata | input | DATA_W | Write word |
| cpu_busy | output | 1 | Memory traffic outstanding; requests are ignored |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_done on reads |
| cmd_inval_all | input | 1 | Invalidate every line |
| cmd_push | input | 1 | Push the line at the given set and way |
| cmd_push_set | input | SET_W | Set of the line to push |
| cmd_push_way | input | WAY_W | Way of the line to push |
| cmd_push_inval | input | 1 | 1 = drop the pushed line, 0 = keep it clean |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W | Line address of the request |
| mem_wdata | output | DATA_W | Line word written to memory |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DATA_W | Line word read, valid with mem_ack |

## Verification
Accesses are issued in an order that steers one set through each stage. It starts empty, fills one invalid way at a time, and is then full with a mix of clean and dirty lines. After that the pointer picks every victim in turn and wraps. Comparing the memory traffic after each access against the model tells apart lowest-invalid placement, pointer choice and dirty versus clean victims. The traffic order separates write-after-fill from write-before-fill. Copyback and write-through accesses hit the same lines, so a write that is wrongly marked modified, or a write-through miss that wrongly allocates, shows up as extra or missing traffic. Reads after an invalidate-all, after both kinds of push, and after a request offered while busy return data that shows whether the discarded or ignored operation touched the line.

// File: rtl/cachectl_pkg.sv
package cachectl_pkg;

    // Line state: bit 1 is the valid flag, bit 0 the modified flag.
    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_VAL = 2'b10,
        LN_MOD = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_FILL,
        FS_THRU,
        FS_DRAIN
    } fsm_e;

    // What an accepted CPU access turns into.
    typedef struct packed {
        logic rd_hit;
        logic wr_hit_cb;
        logic thru;
        logic fill;
    } op_dec_t;

    function automatic op_dec_t decode_op(logic hit, logic we, logic wt);
        op_dec_t d;
        d.rd_hit    = hit & ~we;
        d.wr_hit_cb = hit & we & ~wt;
        d.thru      = we & wt;
        d.fill      = ~hit & ~(we & wt);
        return d;
    endfunction

    function automatic logic is_live(line_st_e s);
        return s[1];
    endfunction

    function automatic line_st_e after_push(logic drop);
        return drop ? LN_INV : LN_VAL;
    endfunction

endpackage

// File: rtl/cc_tag_cmp.sv
module cc_tag_cmp #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             live,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = live[w] && (tags[w] == tag);
    end

    assign hit = |eq;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) hit_way = w[WAY_W-1:0];
        end
    end
endmodule

// File: rtl/cc_victim_pick.sv
module cc_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  live,
    input  logic [WAY_W-1:0] ptr,
    output logic [WAY_W-1:0] way,
    output logic             from_free
);
    always_comb begin
        way       = ptr;
        from_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!live[w]) begin
                way       = w[WAY_W-1:0];
                from_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cc_rr_bank.sv
module cc_rr_bank #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [SET_W-1:0] sel_set,
    output logic [WAY_W-1:0] ptr
);
    logic [SETS-1:0][WAY_W-1:0] ptr_all;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [WAY_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt <= '0;
            end else if (adv && sel_set == SET_W'(s)) begin
                cnt <= cnt + 1'b1;
            end
        end
        assign ptr_all[s] = cnt;
    end

    assign ptr = ptr_all[sel_set];
endmodule

// File: rtl/cc_line_ctrl.sv
module cc_line_ctrl
    import cachectl_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_wt,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cmd_inval_all,
    input  logic              cmd_push,
    input  logic [SET_W-1:0]  cmd_push_set,
    input  logic [WAY_W-1:0]  cmd_push_way,
    input  logic              cmd_push_inval,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    // Line storage
    line_st_e          st_q  [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [DATA_W-1:0] dat_q [SETS][WAYS];

    fsm_e fsm_q;

    // Pending access and victim buffer
    logic [SET_W-1:0]  p_set;
    logic [TAG_W-1:0]  p_tag;
    logic [WAY_W-1:0]  p_way;
    logic              p_we;
    logic [DATA_W-1:0] p_wdata;
    logic              vb_valid;
    logic [ADDR_W-1:0] vb_addr;
    logic [DATA_W-1:0] vb_data;

    // Lookup
    logic [SET_W-1:0]            a_set;
    logic [TAG_W-1:0]            a_tag;
    logic [WAYS-1:0]             set_live;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic [WAY_W-1:0]            rr_ptr;
    logic [WAY_W-1:0]            vict_way;
    logic                        vict_free;
    logic                        any_live;

    assign a_set = cpu_addr[SET_W-1:0];
    assign a_tag = cpu_addr[ADDR_W-1:SET_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_live[w] = is_live(st_q[a_set][w]);
            set_tags[w] = tag_q[a_set][w];
        end
    end

    always_comb begin
        any_live = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                any_live = any_live | is_live(st_q[s][w]);
            end
        end
    end

    cc_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
        .live    (set_live),
        .tags    (set_tags),
        .tag     (a_tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    cc_victim_pick #(.WAYS(WAYS)) u_pick (
        .live      (set_live),
        .ptr       (rr_ptr),
        .way       (vict_way),
        .from_free (vict_free)
    );

    // Acceptance, with invalidate-all ahead of push ahead of CPU access
    logic    idle, do_inval, do_push, do_cpu;
    op_dec_t dec;

    assign idle     = (fsm_q == FS_IDLE);
    assign do_inval = idle && cmd_inval_all;
    assign do_push  = idle && !cmd_inval_all && cmd_push;
    assign do_cpu   = idle && !cmd_inval_all && !cmd_push && cpu_req;
    assign dec      = decode_op(hit, cpu_we, cpu_wt);
    assign cpu_busy = !idle;

    cc_rr_bank #(.SETS(SETS), .WAYS(WAYS)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .adv     (do_cpu && dec.fill && !vict_free),
        .sel_set (a_set),
        .ptr     (rr_ptr)
    );

    // Push target
    line_st_e push_st;
    assign push_st = st_q[cmd_push_set][cmd_push_way];

    // Single write port into tag and data storage
    logic              wr_en;
    logic [SET_W-1:0]  wr_set;
    logic [WAY_W-1:0]  wr_way;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    always_comb begin
        wr_en   = 1'b0;
        wr_set  = a_set;
        wr_way  = hit_way;
        wr_tag  = a_tag;
        wr_data = cpu_wdata;
        if (do_cpu && hit && cpu_we) begin
            wr_en = 1'b1;
        end else if (fsm_q == FS_FILL && mem_ack) begin
            wr_en   = 1'b1;
            wr_set  = p_set;
            wr_way  = p_way;
            wr_tag  = p_tag;
            wr_data = p_we ? p_wdata : mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            dat_q[wr_set][wr_way] <= wr_data;
        end
    end

    // Control and line state
    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q    <= FS_IDLE;
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            cpu_done <= 1'b0;
            vb_valid <= 1'b0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_q[s][w] <= LN_INV;
                end
            end
        end else begin
            cpu_done <= 1'b0;
            unique case (fsm_q)
                FS_IDLE: begin
                    if (do_inval) begin
                        for (int s = 0; s < SETS; s++) begin
                            for (int w = 0; w < WAYS; w++) begin
                                st_q[s][w] <= LN_INV;
                            end
                        end
                    end else if (do_push) begin
                        if (push_st == LN_MOD) begin
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_addr  <= {tag_q[cmd_push_set][cmd_push_way], cmd_push_set};
                            mem_wdata <= dat_q[cmd_push_set][cmd_push_way];
                            st_q[cmd_push_set][cmd_push_way] <= after_push(cmd_push_inval);
                            fsm_q     <= FS_DRAIN;
                        end else if (cmd_push_inval) begin
                            st_q[cmd_push_set][cmd_push_way] <= LN_INV;
                        end
                    end else if (do_cpu) begin
                        p_set   <= a_set;
                        p_tag   <= a_tag;
                        p_we    <= cpu_we;
                        p_wdata <= cpu_wdata;
                        if (dec.rd_hit) begin
                            cpu_rdata <= dat_q[a_set][hit_way];
                            cpu_done  <= 1'b1;
                        end else if (dec.wr_hit_cb) begin
                            st_q[a_set][hit_way] <= LN_MOD;
                            cpu_done <= 1'b1;
                        end else if (dec.thru) begin
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_addr  <= cpu_addr;
                            mem_wdata <= cpu_wdata;
                            fsm_q     <= FS_THRU;
                        end else begin
                            p_way    <= vict_way;
                            vb_valid <= (st_q[a_set][vict_way] == LN_MOD);
                            vb_addr  <= {tag_q[a_set][vict_way], a_set};
                            vb_data  <= dat_q[a_set][vict_way];
                            st_q[a_set][vict_way] <= LN_INV;
                            mem_req  <= 1'b1;
                            mem_we   <= 1'b0;
                            mem_addr <= cpu_addr;
                            fsm_q    <= FS_FILL;
                        end
                    end
                end
                FS_FILL: begin
                    if (mem_ack) begin
                        st_q[p_set][p_way] <= p_we ? LN_MOD : LN_VAL;
                        cpu_rdata <= p_we ? p_wdata : mem_rdata;
                        cpu_done  <= 1'b1;
                        if (vb_valid) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= vb_addr;
                            mem_wdata <= vb_data;
                            fsm_q     <= FS_DRAIN;
                        end else begin
                            mem_req <= 1'b0;
                            fsm_q   <= FS_IDLE;
                        end
                    end
                end
                FS_THRU: begin
                    if (mem_ack) begin
                        mem_req  <= 1'b0;
                        cpu_done <= 1'b1;
                        fsm_q    <= FS_IDLE;
                    end
                end
                FS_DRAIN: begin
                    if (mem_ack) begin
                        mem_req  <= 1'b0;
                        vb_valid <= 1'b0;
                        fsm_q    <= FS_IDLE;
                    end
                end
                default: fsm_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cc_line_ctrl_chk.sv
module cc_line_ctrl_chk
    import cachectl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_busy,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              cmd_inval_all,
    input logic              any_live,
    input logic              vb_valid,
    input fsm_e              fsm_q
);
    // R1: reset leaves no live line and no activity
    p_reset_clean_r1: assert property (@(posedge clk)
        rst |=> (!any_live && !mem_req && !cpu_busy && !cpu_done));

    // R9: a memory request is held unchanged until acknowledged
    p_req_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: memory traffic only while busy is shown to the CPU
    p_busy_covers_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cpu_busy);

    // R3: the fill request is a read
    p_fill_reads_r3: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == FS_FILL && mem_req) |-> !mem_we);

    // R8: a buffered dirty victim goes out right after the fill completes
    p_wb_follows_r8: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == FS_FILL && mem_ack && vb_valid) |=> (mem_req && mem_we));

    // R10: invalidate-all leaves no live line
    p_inval_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_inval_all && !cpu_busy) |=> !any_live);
endmodule

bind cc_line_ctrl cc_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_busy      (cpu_busy),
    .cpu_done      (cpu_done),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_ack       (mem_ack),
    .cmd_inval_all (cmd_inval_all),
    .any_live      (any_live),
    .vb_valid      (vb_valid),
    .fsm_q         (fsm_q)
);

// File: tb/cc_line_ctrl_tb.sv
`timescale 1ns/1ps
module cc_line_ctrl_tb;
    localparam int NS = 4;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_wt = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_busy, cpu_done;
    logic [31:0] cpu_rdata;
    logic        cmd_inval_all = 1'b0, cmd_push = 1'b0, cmd_push_inval = 1'b0;
    logic [1:0]  cmd_push_set = '0, cmd_push_way = '0;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    cc_line_ctrl u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wt(cpu_wt),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .cmd_inval_all(cmd_inval_all), .cmd_push(cmd_push),
        .cmd_push_set(cmd_push_set), .cmd_push_way(cmd_push_way),
        .cmd_push_inval(cmd_push_inval),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int nchk = 0, nfail = 0;
    bit op_pending = 1'b0;
    bit run_over = 1'b0;

    // Memory seen by the block, and the bench's own expectations
    logic [31:0] bmem [256];
    logic [31:0] mmem [256];
    int          m_st  [NS][NW];   // 0 invalid, 1 valid, 2 modified
    int          m_tag [NS][NW];
    logic [31:0] m_dat [NS][NW];
    int          m_rr  [NS];
    int          exp_q [$];
    int          obs_q [$];
    int          lat = 0;

    task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    // Memory responder: two-cycle latency, one-cycle acknowledge
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            lat = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            lat = 0;
        end else if (mem_req) begin
            lat++;
            if (lat >= 2) begin
                mem_ack = 1'b1;
                obs_q.push_back((mem_we ? 65536 : 0) | int'(mem_addr));
                if (mem_we) bmem[mem_addr] = mem_wdata;
                else mem_rdata = bmem[mem_addr];
            end
        end
    end

    // Per-clock comparison: no completion pulse outside an access
    always @(negedge clk) begin
        if (!rst && !op_pending && cpu_done)
            check(1'b0, "R9", "done without a pending access", 32'd1, 32'd0);
    end

    task automatic cmp_traffic(string rq);
        check(obs_q.size() == exp_q.size(), rq, "memory request count",
              obs_q.size(), exp_q.size());
        for (int i = 0; i < obs_q.size() && i < exp_q.size(); i++)
            check(obs_q[i] == exp_q[i], rq, "memory request (we<<16|addr)",
                  obs_q[i], exp_q[i]);
        obs_q.delete();
        exp_q.delete();
    endtask

    function automatic int find_way(int addr);
        int s = addr % NS;
        int t = addr / NS;
        for (int w = 0; w < NW; w++)
            if (m_st[s][w] != 0 && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    task automatic model_cpu(bit we, bit wt, int addr, logic [31:0] wd, output logic [31:0] rd);
        int s = addr % NS;
        int t = addr / NS;
        int hw = find_way(addr);
        rd = '0;
        if (hw >= 0) begin
            if (!we) rd = m_dat[s][hw];
            else begin
                m_dat[s][hw] = wd;
                if (!wt) m_st[s][hw] = 2;
                else begin
                    exp_q.push_back(65536 | addr);
                    mmem[addr] = wd;
                end
            end
        end else if (we && wt) begin
            exp_q.push_back(65536 | addr);
            mmem[addr] = wd;
        end else begin
            int v = -1;
            for (int w = NW - 1; w >= 0; w--) if (m_st[s][w] == 0) v = w;
            if (v < 0) begin
                v = m_rr[s];
                m_rr[s] = (v + 1) % NW;
            end
            exp_q.push_back(addr);
            rd = mmem[addr];
            if (m_st[s][v] == 2) begin
                int va = m_tag[s][v] * NS + s;
                exp_q.push_back(65536 | va);
                mmem[va] = m_dat[s][v];
            end
            m_tag[s][v] = t;
            m_dat[s][v] = we ? wd : mmem[addr];
            m_st[s][v]  = we ? 2 : 1;
        end
    endtask

    task automatic wait_idle();
        while (cpu_busy) @(negedge clk);
    endtask

    task automatic cpu_op(string rq, bit we, bit wt, int addr, logic [31:0] wd, int want_cyc);
        logic [31:0] rd;
        int n;
        model_cpu(we, wt, addr, wd, rd);
        wait_idle();
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_wt = wt;
        cpu_addr = addr[7:0]; cpu_wdata = wd;
        op_pending = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        n = 1;
        while (!cpu_done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(cpu_done, rq, "completion pulse", cpu_done, 1);
        if (!we) check(cpu_rdata == rd, rq, "read data", cpu_rdata, rd);
        if (want_cyc > 0) check(n == want_cyc, rq, "cycles to completion", n, want_cyc);
        wait_idle();
        cmp_traffic(rq);
        @(negedge clk);
        op_pending = 1'b0;
    endtask

    task automatic push_op(string rq, int addr, bit drop);
        int s = addr % NS;
        int w = find_way(addr);
        if (w < 0) begin
            check(1'b0, rq, "push target resident", 0, 1);
            return;
        end
        if (m_st[s][w] == 2) begin
            exp_q.push_back(65536 | addr);
            mmem[addr] = m_dat[s][w];
            m_st[s][w] = drop ? 0 : 1;
        end else if (drop) m_st[s][w] = 0;
        wait_idle();
        @(negedge clk);
        cmd_push = 1'b1; cmd_push_set = s[1:0]; cmd_push_way = w[1:0];
        cmd_push_inval = drop;
        @(negedge clk);
        cmd_push = 1'b0;
        @(negedge clk);
        wait_idle();
        cmp_traffic(rq);
    endtask

    task automatic inval_all_op(string rq);
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) m_st[s][w] = 0;
        wait_idle();
        @(negedge clk);
        cmd_inval_all = 1'b1;
        @(negedge clk);
        cmd_inval_all = 1'b0;
        check(!cpu_busy, rq, "busy after invalidate-all", cpu_busy, 0);
        repeat (4) @(negedge clk);
        cmp_traffic(rq);
    endtask

    // Miss with a stray request offered while busy
    task automatic busy_ignore_op();
        logic [31:0] rd;
        int n;
        model_cpu(1'b0, 1'b0, 8'h06, 32'h0, rd);
        wait_idle();
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_wt = 1'b0; cpu_addr = 8'h06;
        op_pending = 1'b1;
        @(negedge clk);
        check(cpu_busy, "R9", "busy after accepting a miss", cpu_busy, 1);
        cpu_we = 1'b1; cpu_addr = 8'h03; cpu_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        cpu_req = 1'b0;
        n = 0;
        while (!cpu_done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(cpu_rdata == rd, "R9", "read data of the miss", cpu_rdata, rd);
        wait_idle();
        cmp_traffic("R9");
        @(negedge clk);
        op_pending = 1'b0;
    endtask

    task automatic finish_run();
        if (!run_over) begin
            run_over = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 32'hA500_0000 + 32'(i * 7);
            mmem[i] = bmem[i];
        end
        for (int s = 0; s < NS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < NW; w++) begin
                m_st[s][w] = 0;
                m_tag[s][w] = 0;
                m_dat[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!cpu_busy, "R1", "busy after reset", cpu_busy, 0);
        check(!mem_req, "R1", "mem_req after reset", mem_req, 0);
        check(!cpu_done, "R1", "done after reset", cpu_done, 0);

        cpu_op("R1/R3", 0, 0, 8'h01, 0, 0);          // first access misses
        cpu_op("R2", 0, 0, 8'h01, 0, 1);             // read hit, one cycle
        cpu_op("R4", 1, 0, 8'h01, 32'h1111_0001, 1); // copyback write hit
        cpu_op("R2", 0, 0, 8'h01, 0, 1);
        cpu_op("R4/R6", 1, 0, 8'h05, 32'h2222_0005, 0); // write miss, way 1
        cpu_op("R3/R6", 0, 1, 8'h09, 0, 0);          // write-through read miss
        cpu_op("R5", 1, 1, 8'h09, 32'h3333_0009, 0); // write-through hit
        cpu_op("R5", 0, 0, 8'h09, 0, 1);             // still cached, clean
        cpu_op("R5", 1, 1, 8'h22, 32'h4444_0022, 0); // write-through miss
        cpu_op("R5", 0, 0, 8'h22, 0, 0);             // no allocation: misses
        cpu_op("R6", 0, 0, 8'h0D, 0, 0);             // last free way of set 1
        cpu_op("R7/R8", 0, 0, 8'h11, 0, 0);          // evicts dirty way 0
        cpu_op("R7/R8", 0, 0, 8'h15, 0, 0);          // evicts dirty way 1
        cpu_op("R7/R8", 0, 0, 8'h01, 0, 0);          // clean victim, data back
        cpu_op("R7", 0, 0, 8'h19, 0, 0);
        cpu_op("R7", 0, 0, 8'h1D, 0, 0);             // pointer wraps
        cpu_op("R8", 0, 0, 8'h05, 0, 0);             // written-back word returns

        busy_ignore_op();
        cpu_op("R9", 0, 0, 8'h03, 0, 0);             // stray write left no trace

        cpu_op("R11", 1, 0, 8'h07, 32'h5555_0007, 0);
        push_op("R11", 8'h07, 1'b0);                 // write back, keep
        push_op("R11", 8'h07, 1'b0);                 // clean: no traffic
        cpu_op("R11", 0, 0, 8'h07, 0, 1);            // kept valid
        cpu_op("R11", 1, 0, 8'h07, 32'h6666_0007, 1);
        push_op("R11", 8'h07, 1'b1);                 // write back, drop
        cpu_op("R11", 0, 0, 8'h07, 0, 0);            // dropped: misses

        cpu_op("R10", 1, 0, 8'h0B, 32'h7777_000B, 0);
        inval_all_op("R10");
        cpu_op("R10", 0, 0, 8'h0B, 0, 0);            // old memory word
        cpu_op("R10", 0, 0, 8'h07, 0, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule